// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 interrupt inputs and drives two requests toward a processor: a normal request that is arbitrated by priority and a fast request that bypasses arbitration. Input 0 feeds the fast request directly. Inputs 1 to 31 each carry a 3-bit priority level, an edge or level detection mode, an optional polarity inversion and a 32-bit vector value. Software reaches all of this through a simple word-addressed register port with a write strobe, a read strobe and a read data register that is valid on the cycle after the read strobe.

The interrupt handler reads the current-vector register to find out which handler to run. That read also records the new priority level on an 8-entry hardware stack and clears the edge latch of the winning source. Only an input whose level is strictly higher than the top of the stack can raise the normal request again, which gives nesting. A write to the end-of-service register pops the stack. A protect bit makes vector reads free of side effects, which is needed for debug tools. When protect is set, software performs the stacking by writing the current-vector register. When nothing qualifies at read time, a programmable spurious vector is returned instead.

Any normal input can be forced onto the fast request. A global mask silences both requests, but a wake output still shows any enabled pending input. Synchronisation of asynchronous pins is left to the surrounding logic.

Top module: `vic_top`

## Requirements
- R1: An enabled, pending input 0 raises fastIrqOut and never normIrqOut. A read of word address 0x47 (fast vector) returns the vector of input 0 when input 0 or any forced input is enabled and pending.
- R2: Among enabled, pending, unforced inputs 1..31, the winner has the highest level. A tie goes to the lowest input number. The current-vector register at word address 0x46 returns the winner's vector.
- R3: A side-effecting current-vector access pushes the winner's level onto the 8-entry stack. While the stack is non-empty, normIrqOut is raised only for a winner whose level is strictly above the stack top.
- R4: A write to word address 0x48 pops the stack. When the stack is empty, that write leaves the stack unchanged.
- R5: Word addresses 0x00+n hold the 32-bit vector of input n. They can be read and written.
- R6: The config word at 0x20+n holds the level in bits [2:0], edge mode in bit 4 and inversion in bit 5. In edge mode a 0-to-1 change of the (possibly inverted) input sets a latch. That latch is cleared when the input wins a side-effecting current-vector access. In level mode the pending state follows the (possibly inverted) input.
- R7: With protect (bit 1 of the control word at 0x49) set, reading 0x46 neither pushes the stack nor clears an edge latch. Writing 0x46 then performs both side effects.
- R8: When no input qualifies as winner at the time of a current-vector or fast-vector read, the read returns the spurious vector held at 0x4A.
- R9: With the global mask (bit 0 of 0x49) set, normIrqOut and fastIrqOut stay low. wakeOut is high whenever any enabled input is pending, whatever the mask.
- R10: Bits written as 1 to 0x43 force inputs onto the fast request, and bits written as 1 to 0x44 release them. A forced input neither drives normIrqOut nor has its edge latch cleared by a vector read. A 1 written to 0x4B clears that input's edge latch.
- R11: Writing 1s to 0x40 enables inputs and writing 1s to 0x41 disables them. The enable set is read at 0x42, and the forced set is read at 0x45.
- R12: A fast-vector read never changes the priority stack.
- R13: After reset, all outputs are low. All enables, forces, the control word and the spurious vector are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | 32 | Synchronised interrupt inputs |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 7 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRd |
| normIrqOut | output | 1 | Prioritised normal interrupt request |
| fastIrqOut | output | 1 | Fast interrupt request |
| wakeOut | output | 1 | Enabled input pending, unaffected by the mask |

## Verification
The hardest state to reach is a stack several levels deep, where a pending lower or equal level must stay silent. Reaching it takes a sequence of vector reads while progressively higher inputs are held active. The bench builds this chain on purpose and then unwinds it with end-of-service writes. It adds one extra pop on an empty stack and then a push, so that a wrapped depth counter would show up as a wrong normIrqOut. Seeded random rounds program random levels, polarities, enables and input patterns. They read the vector under protect and compare it with a bench-computed winner.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC        = 32;
  localparam int PRIO_W      = 3;
  localparam int VEC_W       = 32;
  localparam int ADDR_W      = 7;
  localparam int STACK_DEPTH = 8;
  localparam int IDX_W       = $clog2(NSRC);

  localparam logic [1:0] GRP_VEC = 2'd0;
  localparam logic [1:0] GRP_CFG = 2'd1;
  localparam logic [1:0] GRP_CTL = 2'd2;

  localparam logic [4:0] REG_ENSET = 5'd0;
  localparam logic [4:0] REG_ENCLR = 5'd1;
  localparam logic [4:0] REG_ENRD  = 5'd2;
  localparam logic [4:0] REG_FFSET = 5'd3;
  localparam logic [4:0] REG_FFCLR = 5'd4;
  localparam logic [4:0] REG_FFRD  = 5'd5;
  localparam logic [4:0] REG_CUR   = 5'd6;
  localparam logic [4:0] REG_FAST  = 5'd7;
  localparam logic [4:0] REG_EOI   = 5'd8;
  localparam logic [4:0] REG_CTRL  = 5'd9;
  localparam logic [4:0] REG_SPUR  = 5'd10;
  localparam logic [4:0] REG_PCLR  = 5'd11;

  typedef enum logic [3:0] {
    RD_NONE, RD_VEC, RD_CFG, RD_EN, RD_FF, RD_CUR, RD_FAST, RD_CTRL, RD_SPUR
  } rdSel_e;

  typedef struct packed {
    logic             wrVec;
    logic             wrCfg;
    logic             enSet;
    logic             enClr;
    logic             ffSet;
    logic             ffClr;
    logic             curAck;
    logic             fastAck;
    logic             eoi;
    logic             wrCtrl;
    logic             wrSpur;
    logic             pendClr;
    logic             rdEn;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int PW = PRIO_W,
  parameter int IW = IDX_W
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] prio [N],
  output logic          valid,
  output logic [IW-1:0] idx,
  output logic [PW-1:0] level
);
  // Strict greater-than keeps the earliest (lowest-numbered) source on ties.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    level = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!valid || prio[i] > level)) begin
        valid = 1'b1;
        idx   = IW'(i);
        level = prio[i];
      end
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          busWr,
  input  logic          busRd,
  input  logic [AW-1:0] busAddr,
  input  logic          protect,
  output strobe_t       st
);
  logic [1:0] grp;
  logic [4:0] reg5;

  assign grp  = busAddr[AW-1:AW-2];
  assign reg5 = busAddr[4:0];

  always_comb begin
    st      = '0;
    st.idx  = busAddr[IDX_W-1:0];
    st.rdEn = busRd;
    unique case (grp)
      GRP_VEC: begin
        st.wrVec = busWr;
        if (busRd) st.rdSel = RD_VEC;
      end
      GRP_CFG: begin
        st.wrCfg = busWr;
        if (busRd) st.rdSel = RD_CFG;
      end
      GRP_CTL: begin
        case (reg5)
          REG_ENSET: st.enSet   = busWr;
          REG_ENCLR: st.enClr   = busWr;
          REG_ENRD:  if (busRd) st.rdSel = RD_EN;
          REG_FFSET: st.ffSet   = busWr;
          REG_FFCLR: st.ffClr   = busWr;
          REG_FFRD:  if (busRd) st.rdSel = RD_FF;
          REG_CUR: begin
            if (busRd) st.rdSel = RD_CUR;
            st.curAck = (busRd && !protect) || (busWr && protect);
          end
          REG_FAST: begin
            if (busRd) st.rdSel = RD_FAST;
            st.fastAck = busRd && !protect;
          end
          REG_EOI:   st.eoi     = busWr;
          REG_CTRL: begin
            st.wrCtrl = busWr;
            if (busRd) st.rdSel = RD_CTRL;
          end
          REG_SPUR: begin
            st.wrSpur = busWr;
            if (busRd) st.rdSel = RD_SPUR;
          end
          REG_PCLR:  st.pendClr = busWr;
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int N     = NSRC,
  parameter int PW    = PRIO_W,
  parameter int VW    = VEC_W,
  parameter int DEPTH = STACK_DEPTH
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  srcIn,
  input  logic [VW-1:0] wdata,
  input  strobe_t       st,
  output logic [VW-1:0] rdata,
  output logic          normIrq,
  output logic          fastIrq,
  output logic          wake,
  output logic          protect
);
  localparam int DW  = $clog2(DEPTH + 1);
  localparam int SPW = $clog2(DEPTH);

  logic [VW-1:0] vecReg [N];
  logic [PW-1:0] prioReg [N];
  logic [N-1:0]  edgeMode, invert, prevSample, edgeLatch;
  logic [N-1:0]  sample, pending, active, normReq;
  logic [N-1:0]  enMask, ffMask;
  logic          gmask;
  logic [VW-1:0] spurVec;
  logic [PW-1:0] stack [DEPTH];
  logic [DW-1:0] depth, depthM1;
  logic [PW-1:0] curLevel;

  logic          bestValid;
  logic [IDX_W-1:0] bestIdx;
  logic [PW-1:0] bestLevel;
  logic          candValid, fastAny, push, pop;

  // Per-source detection and storage
  for (genvar i = 0; i < N; i++) begin : g_src
    assign sample[i]  = srcIn[i] ^ invert[i];
    assign pending[i] = edgeMode[i] ? edgeLatch[i] : sample[i];

    logic hit;
    logic ackClr;
    assign hit    = (st.idx == IDX_W'(i));
    assign ackClr = (st.curAck && candValid && bestIdx == IDX_W'(i))
                 || (st.fastAck && i == 0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vecReg[i]     <= '0;
        prioReg[i]    <= '0;
        edgeMode[i]   <= 1'b0;
        invert[i]     <= 1'b0;
        prevSample[i] <= 1'b0;
        edgeLatch[i]  <= 1'b0;
      end else begin
        prevSample[i] <= sample[i];
        if (st.wrVec && hit) vecReg[i] <= wdata;
        if (st.wrCfg && hit) begin
          prioReg[i]  <= wdata[PW-1:0];
          edgeMode[i] <= wdata[4];
          invert[i]   <= wdata[5];
        end
        if (sample[i] && !prevSample[i])
          edgeLatch[i] <= 1'b1;
        else if ((st.pendClr && wdata[i]) || ackClr)
          edgeLatch[i] <= 1'b0;
      end
    end
  end

  assign active  = pending & enMask;
  assign normReq = active & ~ffMask & {{(N-1){1'b1}}, 1'b0};
  assign fastAny = active[0] || (|(active[N-1:1] & ffMask[N-1:1]));

  vic_arbiter #(.N(N), .PW(PW), .IW(IDX_W)) u_arb (
    .req   (normReq),
    .prio  (prioReg),
    .valid (bestValid),
    .idx   (bestIdx),
    .level (bestLevel)
  );

  // Priority stack
  assign depthM1   = depth - 1'b1;
  assign curLevel  = (depth == '0) ? '0 : stack[depthM1[SPW-1:0]];
  assign candValid = bestValid && ((depth == '0) || (bestLevel > curLevel));
  assign push      = st.curAck && candValid && (depth < DW'(DEPTH));
  assign pop       = st.eoi && (depth != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
      for (int k = 0; k < DEPTH; k++) stack[k] <= '0;
    end else if (push) begin
      stack[depth[SPW-1:0]] <= bestLevel;
      depth <= depth + 1'b1;
    end else if (pop) begin
      depth <= depthM1;
    end
  end

  // Global registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask  <= '0;
      ffMask  <= '0;
      gmask   <= 1'b0;
      protect <= 1'b0;
      spurVec <= '0;
    end else begin
      if (st.enSet) enMask <= enMask | wdata[N-1:0];
      if (st.enClr) enMask <= enMask & ~wdata[N-1:0];
      if (st.ffSet) ffMask <= ffMask | wdata[N-1:0];
      if (st.ffClr) ffMask <= ffMask & ~wdata[N-1:0];
      if (st.wrCtrl) begin
        gmask   <= wdata[0];
        protect <= wdata[1];
      end
      if (st.wrSpur) spurVec <= wdata;
    end
  end

  // Read data and outputs
  logic [VW-1:0] cfgWord;
  always_comb begin
    cfgWord = '0;
    cfgWord[PW-1:0] = prioReg[st.idx];
    cfgWord[4] = edgeMode[st.idx];
    cfgWord[5] = invert[st.idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata   <= '0;
      normIrq <= 1'b0;
      fastIrq <= 1'b0;
      wake    <= 1'b0;
    end else begin
      normIrq <= candValid && !gmask;
      fastIrq <= fastAny && !gmask;
      wake    <= |active;
      if (st.rdEn) begin
        case (st.rdSel)
          RD_VEC:  rdata <= vecReg[st.idx];
          RD_CFG:  rdata <= cfgWord;
          RD_EN:   rdata <= VW'(enMask);
          RD_FF:   rdata <= VW'(ffMask);
          RD_CUR:  rdata <= candValid ? vecReg[bestIdx] : spurVec;
          RD_FAST: rdata <= fastAny ? vecReg[0] : spurVec;
          RD_CTRL: rdata <= VW'({protect, gmask});
          RD_SPUR: rdata <= spurVec;
          default: rdata <= '0;
        endcase
      end
    end
  end

  // Assertions
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.curAck && candValid) |-> (depth < DW'(DEPTH)));

  p_pop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.eoi && depth != '0) |=> (depth == $past(depth) - 1'b1));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.eoi && depth == '0) |=> (depth == '0));

  p_protect_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && st.rdSel == RD_CUR && protect) |=> $stable(depth));

  p_gmask_r9: assert property (@(posedge clk) disable iff (!rstN)
    gmask |=> (!normIrq && !fastIrq));

  p_fast_stack_r12: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && st.rdSel == RD_FAST) |=> $stable(depth));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [VEC_W-1:0]  busWdata,
  output logic [VEC_W-1:0]  busRdata,
  output logic              normIrqOut,
  output logic              fastIrqOut,
  output logic              wakeOut
);
  strobe_t strobes;
  logic    protect;

  vic_ctrl #(.AW(ADDR_W)) u_ctrl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .protect (protect),
    .st      (strobes)
  );

  vic_datapath #(.N(NSRC), .PW(PRIO_W), .VW(VEC_W), .DEPTH(STACK_DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .wdata   (busWdata),
    .st      (strobes),
    .rdata   (busRdata),
    .normIrq (normIrqOut),
    .fastIrq (fastIrqOut),
    .wake    (wakeOut),
    .protect (protect)
  );

  p_one_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.curAck, strobes.fastAck, strobes.eoi}));
endmodule

// File: tb/vic_top_tb.sv
module vic_top_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [6:0] A_ENSET = 7'h40, A_ENCLR = 7'h41, A_ENRD = 7'h42;
  localparam logic [6:0] A_FFSET = 7'h43, A_FFCLR = 7'h44, A_FFRD = 7'h45;
  localparam logic [6:0] A_CUR = 7'h46, A_FAST = 7'h47, A_EOI = 7'h48;
  localparam logic [6:0] A_CTRL = 7'h49, A_SPUR = 7'h4A, A_PCLR = 7'h4B;
  localparam logic [31:0] SPUR = 32'hDEAD_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        normIrqOut, fastIrqOut, wakeOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_top u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .normIrqOut(normIrqOut), .fastIrqOut(fastIrqOut), .wakeOut(wakeOut)
  );

  function automatic logic [31:0] vecVal(int i);
    return 32'h4000_0000 + 32'(i) * 32'h104;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic cleanup();
    srcIn = '0;
    wr(A_ENCLR, '1);
    wr(A_FFCLR, '1);
    wr(A_PCLR, '1);
    for (int k = 0; k < 9; k++) wr(A_EOI, '0);
    wr(A_CTRL, '0);
    settle(3);
  endtask

  function automatic logic [31:0] expWinner(logic [31:0] act, logic [2:0] pr [32],
                                            output bit found);
    int best = 0;
    found = 1'b0;
    for (int i = 1; i < 32; i++)
      if (act[i] && (!found || pr[i] > pr[best])) begin
        found = 1'b1; best = i;
      end
    return found ? vecVal(best) : SPUR;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [2:0]  pr [32];
    logic [31:0] inv, en, act;
    bit          found;
    void'($urandom(32'd1234));

    settle(3);
    // R13 reset state
    chk("R13 normIrq", 32'(normIrqOut), 0);
    chk("R13 fastIrq", 32'(fastIrqOut), 0);
    chk("R13 wake", 32'(wakeOut), 0);
    rstN = 1'b1;
    settle(2);
    rd(A_CTRL, d); chk("R13 ctrl", d, 0);
    rd(A_ENRD, d); chk("R13 enables", d, 0);
    rd(A_FFRD, d); chk("R13 forces", d, 0);
    rd(A_SPUR, d); chk("R13 spurious", d, 0);

    // R5 vectors
    for (int i = 0; i < 32; i++) wr(7'(i), vecVal(i));
    wr(A_SPUR, SPUR);
    rd(7'd17, d); chk("R5 vec17", d, vecVal(17));
    rd(7'd0, d);  chk("R5 vec0", d, vecVal(0));

    // R11 enable / force set-clear
    wr(A_ENSET, 32'h0000_00F0);
    wr(A_ENSET, 32'h0000_0F00);
    rd(A_ENRD, d); chk("R11 enable set", d, 32'h0000_0FF0);
    wr(A_ENCLR, 32'h0000_0030);
    rd(A_ENRD, d); chk("R11 enable clear", d, 32'h0000_0FC0);
    wr(A_FFSET, 32'h8000_0002);
    wr(A_FFCLR, 32'h0000_0002);
    rd(A_FFRD, d); chk("R11 force set", d, 32'h8000_0000);
    cleanup();

    // R2 priority and tie
    wr(7'h20 + 7'd3, 32'h2);
    wr(7'h20 + 7'd5, 32'h6);
    wr(7'h20 + 7'd7, 32'h6);
    rd(7'h25, d); chk("R6 cfg readback", d, 32'h6);
    wr(A_ENSET, 32'h0000_00A8);
    srcIn = 32'h0000_00A8;
    wr(A_CTRL, 32'h2);
    settle(3);
    chk("R2 irq", 32'(normIrqOut), 1);
    rd(A_CUR, d); chk("R2 tie lowest", d, vecVal(5));

    // R3 nesting
    wr(A_CTRL, 32'h0);
    rd(A_CUR, d); chk("R3 push read", d, vecVal(5));
    settle(2);
    chk("R3 equal level silent", 32'(normIrqOut), 0);
    wr(7'h20 + 7'd9, 32'h7);
    wr(A_ENSET, 32'h0000_0200);
    srcIn[9] = 1'b1;
    settle(3);
    chk("R3 preempt", 32'(normIrqOut), 1);
    rd(A_CUR, d); chk("R3 nested vec", d, vecVal(9));
    settle(2);
    chk("R3 top level silent", 32'(normIrqOut), 0);
    wr(A_EOI, 0); settle(2);
    chk("R4 pop to 6", 32'(normIrqOut), 1);
    srcIn[9] = 1'b0; settle(3);
    chk("R4 level 6 in service", 32'(normIrqOut), 0);
    wr(A_EOI, 0); settle(2);
    chk("R4 pop to empty", 32'(normIrqOut), 1);
    wr(A_EOI, 0); settle(2);
    rd(A_CUR, d); chk("R4 after empty pop", d, vecVal(5));
    settle(2);
    chk("R4 empty pop ignored", 32'(normIrqOut), 0);
    wr(A_EOI, 0); settle(2);
    chk("R4 single pop", 32'(normIrqOut), 1);
    cleanup();

    // R8 spurious
    wr(7'h20 + 7'd20, 32'h3);
    wr(A_ENSET, 32'h0010_0000);
    srcIn[20] = 1'b1; settle(3);
    chk("R8 pending", 32'(normIrqOut), 1);
    srcIn[20] = 1'b0; settle(3);
    rd(A_CUR, d); chk("R8 spurious", d, SPUR);
    rd(A_FAST, d); chk("R8 fast spurious", d, SPUR);
    chk("R8 irq low", 32'(normIrqOut), 0);

    // R9 global mask and wake
    srcIn[20] = 1'b1;
    wr(A_CTRL, 32'h1); settle(3);
    chk("R9 irq masked", 32'(normIrqOut), 0);
    chk("R9 fast masked", 32'(fastIrqOut), 0);
    chk("R9 wake", 32'(wakeOut), 1);
    wr(A_CTRL, 32'h0); settle(2);
    chk("R9 unmasked", 32'(normIrqOut), 1);
    cleanup();

    // R6 rising edge
    wr(7'h20 + 7'd12, 32'h14);
    wr(A_ENSET, 32'h0000_1000);
    @(negedge clk); srcIn[12] = 1'b1; @(negedge clk); srcIn[12] = 1'b0;
    settle(3);
    chk("R6 edge latched", 32'(normIrqOut), 1);
    rd(A_CUR, d); chk("R6 edge vec", d, vecVal(12));
    wr(A_EOI, 0); settle(2);
    chk("R6 edge cleared", 32'(normIrqOut), 0);

    // R7 protect
    wr(A_CTRL, 32'h2);
    @(negedge clk); srcIn[12] = 1'b1; @(negedge clk); srcIn[12] = 1'b0;
    settle(3);
    rd(A_CUR, d); chk("R7 read 1", d, vecVal(12));
    rd(A_CUR, d); chk("R7 read 2", d, vecVal(12));
    settle(2);
    chk("R7 no side effect", 32'(normIrqOut), 1);
    wr(A_CUR, 0); settle(2);
    chk("R7 write acks", 32'(normIrqOut), 0);
    wr(A_EOI, 0); settle(2);
    chk("R7 edge cleared by write", 32'(normIrqOut), 0);
    wr(A_CTRL, 0);
    cleanup();

    // R6 low level and falling edge
    wr(7'h20 + 7'd13, 32'h21);
    wr(A_ENSET, 32'h0000_2000);
    settle(3);
    chk("R6 low level", 32'(normIrqOut), 1);
    srcIn[13] = 1'b1; settle(3);
    chk("R6 low level gone", 32'(normIrqOut), 0);
    wr(A_ENCLR, 32'h0000_2000);
    srcIn[14] = 1'b1;
    wr(7'h20 + 7'd14, 32'h32);
    wr(A_PCLR, 32'h0000_4000);
    wr(A_ENSET, 32'h0000_4000);
    settle(2);
    chk("R6 falling idle", 32'(normIrqOut), 0);
    srcIn[14] = 1'b0; settle(3);
    chk("R6 falling edge", 32'(normIrqOut), 1);
    rd(A_CUR, d); chk("R6 falling vec", d, vecVal(14));
    cleanup();

    // R1 fast source
    wr(A_ENSET, 32'h1);
    srcIn[0] = 1'b1; settle(3);
    chk("R1 fast", 32'(fastIrqOut), 1);
    chk("R1 no normal", 32'(normIrqOut), 0);
    rd(A_FAST, d); chk("R1 fast vec", d, vecVal(0));
    srcIn[0] = 1'b0; settle(3);
    chk("R1 fast drop", 32'(fastIrqOut), 0);

    // R10 forcing
    wr(7'h20 + 7'd22, 32'h17);
    wr(A_ENSET, 32'h0040_0000);
    wr(A_FFSET, 32'h0040_0000);
    @(negedge clk); srcIn[22] = 1'b1; @(negedge clk); srcIn[22] = 1'b0;
    settle(3);
    chk("R10 forced fast", 32'(fastIrqOut), 1);
    chk("R10 forced not normal", 32'(normIrqOut), 0);
    rd(A_FAST, d); chk("R10 fast vec", d, vecVal(0));
    settle(2);
    chk("R10 not auto cleared", 32'(fastIrqOut), 1);
    wr(A_PCLR, 32'h0040_0000); settle(2);
    chk("R10 sw clear", 32'(fastIrqOut), 0);
    wr(A_FFCLR, 32'h0040_0000);
    @(negedge clk); srcIn[22] = 1'b1; @(negedge clk); srcIn[22] = 1'b0;
    settle(3);
    chk("R10 released normal", 32'(normIrqOut), 1);
    rd(A_CUR, d); chk("R10 released vec", d, vecVal(22));
    cleanup();

    // R12 fast read keeps stack
    wr(7'h20 + 7'd5, 32'h6);
    wr(A_ENSET, 32'h0000_0021);
    srcIn[5] = 1'b1; settle(3);
    rd(A_CUR, d); chk("R12 push", d, vecVal(5));
    srcIn[0] = 1'b1; settle(3);
    rd(A_FAST, d); chk("R12 fast vec", d, vecVal(0));
    settle(2);
    chk("R12 still in service", 32'(normIrqOut), 0);
    wr(A_EOI, 0); settle(2);
    chk("R12 one pop empties", 32'(normIrqOut), 1);
    cleanup();

    // R2 random rounds under protect
    wr(A_CTRL, 32'h2);
    for (int it = 0; it < 40; it++) begin
      inv = $urandom() & 32'hFFFF_FFFE;
      en  = $urandom() & 32'hFFFF_FFFE;
      pr[0] = 3'd0;
      for (int i = 1; i < 32; i++) begin
        pr[i] = 3'($urandom_range(0, 7));
        wr(7'h20 + 7'(i), {26'd0, inv[i], 2'b00, pr[i]});
      end
      wr(A_ENCLR, '1);
      wr(A_ENSET, en);
      srcIn = $urandom() & 32'hFFFF_FFFE;
      settle(3);
      act = (srcIn ^ inv) & en;
      d = expWinner(act, pr, found);
      chk("R2 random irq", 32'(normIrqOut), 32'(found));
      rd(A_CUR, d); chk("R2 random vec", d, expWinner(act, pr, found));
      chk("R9 random wake", 32'(wakeOut), 32'(act != 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule